// File: doc/BRIEF.md
# SD/MMC card SPI bring-up sequencer

This block is the host-side controller that takes a memory card from power-up to a usable state over an SPI link. It does not shift bits itself. It drives a byte-wide SPI engine: it asks for one byte exchange at a time, supplies the transmit byte and the chip-select level, and reads back the received byte when the engine reports completion.

After a start request, the sequencer clocks a run of idle bytes with the card deselected. It then works through the reset, interface-condition, operating-condition and capacity commands. From the response codes it decides whether the card is a second-generation SD card, a first-generation SD card or an MMC card, and it retries each stage up to a parameterised limit. When it finishes, it pulses a done strobe and holds a card-type code, a present flag and a bad-card flag until the next start.

Each command follows the same pattern. The sequencer sends a six-byte frame and polls for a response byte. It reads any trailing word, then releases chip select and clocks one more idle byte.

Top module: `sdspi_init_seq`

## Requirements
- R1: After `init_go` is accepted, the first `PRE_BYTES` byte exchanges are 0xFF with `spi_cs_n` high. No command byte is sent before them.
- R2: Every command is six bytes sent with `spi_cs_n` low: 0x40 OR the command index, then a 32-bit argument MSB first, then a check byte. The check byte is 0x95 for command 0, 0x87 for command 8 and 0x01 for all others. The argument is 0x000001AA for command 8, 0x40100000 for command 41 and zero otherwise.
- R3: After a frame, the sequencer sends up to `POLL_BYTES` bytes of 0xFF. The first received byte with bit 7 clear is the response. If no such byte arrives, the response is taken as 0xFF.
- R4: When a command's response and any trailing word are complete, exactly one 0xFF byte is exchanged with `spi_cs_n` high before the next command.
- R5: Command 0 is repeated until the response is 0x01, at most `RST_TRIES` times. If this limit is reached, the run ends with `card_type`=0 (none), `card_present`=0 and `card_bad`=0.
- R6: A command 8 response of 0x01 is followed by reading four more bytes. If they form 0x000001AA, command 58 is issued, its four trailing bytes are read, and the card is classed as SD v2. A different echo, or a response of 0x05, classes the card as SD v1 without command 58. Any other response repeats command 8, at most `IFC_TRIES` times, and then proceeds as SD v1.
- R7: The operating-condition step sends command 55 followed by command 41, and repeats the pair until command 41 answers 0x00. The card is then present, with `card_type` 3 (SD v2) or 2 (SD v1).
- R8: If a command 41 response has bit 2 set, or `ACMD_TRIES` pairs pass without 0x00, the sequencer moves to the MMC path.
- R9: On the MMC path, command 1 with a zero argument is repeated until it answers 0x00, at most `MMC_TRIES` times. Success gives `card_type` 1 with `card_present`=1. Exhaustion gives `card_type` 1, `card_present`=0 and `card_bad`=1.
- R10: `init_done` is a single-cycle pulse. Results are cleared when a start is accepted and are held unchanged after `init_done` until the next accepted start. `init_go` is ignored while a run is in progress.
- R11: A byte request (`spi_start`) is raised only while `spi_busy` is low and no earlier request is still awaiting `spi_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_go | input | 1 | Start a bring-up run (accepted when idle) |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_start | output | 1 | Request one byte exchange |
| spi_tx | output | 8 | Byte to transmit with the request |
| spi_busy | input | 1 | Engine is shifting a byte |
| spi_done | input | 1 | One-cycle pulse: exchange finished, `spi_rx` valid |
| spi_rx | input | 8 | Byte received in the finished exchange |
| card_type | output | 2 | 0 none, 1 MMC, 2 SD v1, 3 SD v2 |
| card_present | output | 1 | Card reached ready state |
| card_bad | output | 1 | MMC card never left its busy state |
| init_done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench builds the sequencer with retry limits of 4, 3, 6 and 5 for the reset, interface-condition, operating-condition and MMC stages. It keeps the ten-byte preamble and the eight-byte poll window. These small limits make exhaustion of every retry loop reachable in a few hundred cycles, so the fallback paths for no card, SD v1, MMC and bad card are all reached. A card model replies with a random number of idle bytes before each response, up to the last poll slot. It also counts every command frame, which lets the exact number of retries on each path be compared with the expected count.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [1:0] {
    CARD_NONE = 2'd0,
    CARD_MMC  = 2'd1,
    CARD_SD1  = 2'd2,
    CARD_SD2  = 2'd3
  } card_kind_t;

  typedef enum logic [2:0] {
    OP_RST = 3'd0,  // command 0
    OP_IFC = 3'd1,  // command 8
    OP_OCR = 3'd2,  // command 58
    OP_APP = 3'd3,  // command 55
    OP_OPC = 3'd4,  // command 41
    OP_MMC = 3'd5   // command 1
  } op_t;

  localparam logic [7:0]  R1_IDLE     = 8'h01;
  localparam logic [7:0]  R1_READY    = 8'h00;
  localparam logic [7:0]  R1_OLDCARD  = 8'h05;
  localparam logic [7:0]  R1_NONE     = 8'hFF;
  localparam int          ILLEGAL_BIT = 2;
  localparam logic [31:0] IFC_ECHO    = 32'h0000_01AA;
  localparam logic [7:0]  IDLE_BYTE   = 8'hFF;
  localparam int          FRAME_LEN   = 6;
  localparam int          TAIL_LEN    = 4;

  function automatic logic [5:0] op_index(op_t o);
    case (o)
      OP_RST:  return 6'd0;
      OP_IFC:  return 6'd8;
      OP_OCR:  return 6'd58;
      OP_APP:  return 6'd55;
      OP_OPC:  return 6'd41;
      default: return 6'd1;
    endcase
  endfunction

  function automatic logic [31:0] op_arg(op_t o);
    case (o)
      OP_IFC:  return IFC_ECHO;
      OP_OPC:  return 32'h4010_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] op_check(op_t o);
    case (o)
      OP_RST:  return 8'h95;
      OP_IFC:  return 8'h87;
      default: return 8'h01;
    endcase
  endfunction

endpackage

// File: rtl/sdinit_frame.sv
module sdinit_frame
  import sdinit_pkg::*;
(
  input  op_t        op,
  input  logic [2:0] idx,
  output logic [7:0] data
);
  logic [31:0] arg;

  always_comb begin
    arg = op_arg(op);
    case (idx)
      3'd0:    data = {2'b01, op_index(op)};
      3'd1:    data = arg[31:24];
      3'd2:    data = arg[23:16];
      3'd3:    data = arg[15:8];
      3'd4:    data = arg[7:0];
      default: data = op_check(op);
    endcase
  end
endmodule

// File: rtl/sdinit_trycnt.sv
module sdinit_trycnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         last
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || inc) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == (limit - 1'b1));
endmodule

// File: rtl/sdinit_capture.sv
module sdinit_capture (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_r1,
  input  logic [7:0]  r1_in,
  input  logic        sh_en,
  input  logic [7:0]  sh_in,
  output logic [7:0]  r1,
  output logic [31:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     r1 <= 8'hFF;
    else if (ld_r1) r1 <= r1_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (sh_en) word <= {word[23:0], sh_in};
  end
endmodule

// File: rtl/sdspi_init_seq.sv
module sdspi_init_seq
  import sdinit_pkg::*;
#(
  parameter int PRE_BYTES  = 10,
  parameter int POLL_BYTES = 8,
  parameter int RST_TRIES  = 255,
  parameter int IFC_TRIES  = 8,
  parameter int ACMD_TRIES = 65535,
  parameter int MMC_TRIES  = 65535
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_go,
  output logic       spi_cs_n,
  output logic       spi_start,
  output logic [7:0] spi_tx,
  input  logic       spi_busy,
  input  logic       spi_done,
  input  logic [7:0] spi_rx,
  output logic [1:0] card_type,
  output logic       card_present,
  output logic       card_bad,
  output logic       init_done
);
  localparam int TRY_A   = (RST_TRIES > IFC_TRIES) ? RST_TRIES : IFC_TRIES;
  localparam int TRY_B   = (ACMD_TRIES > MMC_TRIES) ? ACMD_TRIES : MMC_TRIES;
  localparam int TRY_MAX = (TRY_A > TRY_B) ? TRY_A : TRY_B;
  localparam int TRY_W   = $clog2(TRY_MAX + 1);
  localparam int CNT_A   = (PRE_BYTES > POLL_BYTES) ? PRE_BYTES : POLL_BYTES;
  localparam int CNT_MAX = (CNT_A > 8) ? CNT_A : 8;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_BYTES - 1);
  localparam logic [CNT_W-1:0] POLL_LAST  = CNT_W'(POLL_BYTES - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TAIL_LAST  = CNT_W'(TAIL_LEN - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_TX, S_POLL, S_TAIL, S_GAP, S_EVAL, S_FIN
  } st_t;

  // reset: asserted asynchronously, released on the clock
  logic rsync_q1, rsync_q2, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q1 <= 1'b0;
      rsync_q2 <= 1'b0;
    end else begin
      rsync_q1 <= 1'b1;
      rsync_q2 <= rsync_q1;
    end
  end
  assign rst_i_n = rsync_q2;

  st_t              st_q, st_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  op_t              op_q, op_d;
  logic             v2_q, v2_d;
  logic [1:0]       type_q, type_d;
  logic             pres_q, pres_d;
  logic             bad_q, bad_d;
  logic             res_we;

  logic             try_clr, try_inc, try_last;
  logic [TRY_W-1:0] try_lim;
  logic             ld_r1, sh_en;
  logic [7:0]       r1_in, r1_q;
  logic [31:0]      word_q;
  logic [7:0]       frame_byte;
  logic             byte_st, issue, byte_fin;

  sdinit_frame u_frame (
    .op   (op_q),
    .idx  (cnt_q[2:0]),
    .data (frame_byte)
  );

  always_comb begin
    case (op_q)
      OP_RST:         try_lim = TRY_W'(RST_TRIES);
      OP_IFC:         try_lim = TRY_W'(IFC_TRIES);
      OP_APP, OP_OPC: try_lim = TRY_W'(ACMD_TRIES);
      default:        try_lim = TRY_W'(MMC_TRIES);
    endcase
  end

  sdinit_trycnt #(.W(TRY_W)) u_try (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (try_clr),
    .inc   (try_inc),
    .limit (try_lim),
    .last  (try_last)
  );

  sdinit_capture u_cap (
    .clk   (clk),
    .rst_n (rst_i_n),
    .ld_r1 (ld_r1),
    .r1_in (r1_in),
    .sh_en (sh_en),
    .sh_in (spi_rx),
    .r1    (r1_q),
    .word  (word_q)
  );

  // byte-engine handshake
  assign byte_st  = (st_q == S_PRE) || (st_q == S_TX) || (st_q == S_POLL) ||
                    (st_q == S_TAIL) || (st_q == S_GAP);
  assign issue    = byte_st && !pend_q && !spi_busy;
  assign byte_fin = pend_q && spi_done;

  assign spi_start = issue;
  assign spi_cs_n  = !((st_q == S_TX) || (st_q == S_POLL) || (st_q == S_TAIL));
  assign spi_tx    = (st_q == S_TX) ? frame_byte : IDLE_BYTE;

  always_comb begin
    pend_d = pend_q;
    if (issue)         pend_d = 1'b1;
    else if (byte_fin) pend_d = 1'b0;
  end

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    v2_d    = v2_q;
    type_d  = type_q;
    pres_d  = pres_q;
    bad_d   = bad_q;
    res_we  = 1'b0;
    try_clr = 1'b0;
    try_inc = 1'b0;
    ld_r1   = 1'b0;
    r1_in   = spi_rx;
    sh_en   = 1'b0;

    case (st_q)
      S_IDLE: begin
        if (init_go) begin
          st_d    = S_PRE;
          cnt_d   = '0;
          op_d    = OP_RST;
          v2_d    = 1'b0;
          type_d  = CARD_NONE;
          pres_d  = 1'b0;
          bad_d   = 1'b0;
          res_we  = 1'b1;
          try_clr = 1'b1;
        end
      end

      S_PRE: begin
        if (byte_fin) begin
          if (cnt_q == PRE_LAST) begin
            cnt_d = '0;
            st_d  = S_TX;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end

      S_TX: begin
        if (byte_fin) begin
          if (cnt_q == FRAME_LAST) begin
            cnt_d = '0;
            st_d  = S_POLL;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end

      S_POLL: begin
        if (byte_fin) begin
          if (!spi_rx[7]) begin
            ld_r1 = 1'b1;
            cnt_d = '0;
            if (((op_q == OP_IFC) && (spi_rx == R1_IDLE)) || (op_q == OP_OCR))
              st_d = S_TAIL;
            else
              st_d = S_GAP;
          end else if (cnt_q == POLL_LAST) begin
            ld_r1 = 1'b1;
            r1_in = R1_NONE;
            cnt_d = '0;
            st_d  = S_GAP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end

      S_TAIL: begin
        if (byte_fin) begin
          sh_en = 1'b1;
          if (cnt_q == TAIL_LAST) begin
            cnt_d = '0;
            st_d  = S_GAP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end

      S_GAP: begin
        if (byte_fin) st_d = S_EVAL;
      end

      S_EVAL: begin
        cnt_d = '0;
        st_d  = S_TX;
        case (op_q)
          OP_RST: begin
            if (r1_q == R1_IDLE) begin
              op_d    = OP_IFC;
              try_clr = 1'b1;
            end else if (try_last) begin
              st_d   = S_FIN;
              type_d = CARD_NONE;
              res_we = 1'b1;
            end else begin
              try_inc = 1'b1;
            end
          end
          OP_IFC: begin
            if (r1_q == R1_IDLE) begin
              try_clr = 1'b1;
              if (word_q == IFC_ECHO) begin
                v2_d = 1'b1;
                op_d = OP_OCR;
              end else begin
                op_d = OP_APP;
              end
            end else if ((r1_q == R1_OLDCARD) || try_last) begin
              try_clr = 1'b1;
              op_d    = OP_APP;
            end else begin
              try_inc = 1'b1;
            end
          end
          OP_OCR: begin
            op_d = OP_APP;
          end
          OP_APP: begin
            op_d = OP_OPC;
          end
          OP_OPC: begin
            if (r1_q == R1_READY) begin
              st_d   = S_FIN;
              type_d = v2_q ? CARD_SD2 : CARD_SD1;
              pres_d = 1'b1;
              res_we = 1'b1;
            end else if (r1_q[ILLEGAL_BIT] || try_last) begin
              try_clr = 1'b1;
              op_d    = OP_MMC;
            end else begin
              try_inc = 1'b1;
              op_d    = OP_APP;
            end
          end
          default: begin
            if (r1_q == R1_READY) begin
              st_d   = S_FIN;
              type_d = CARD_MMC;
              pres_d = 1'b1;
              res_we = 1'b1;
            end else if (try_last) begin
              st_d   = S_FIN;
              type_d = CARD_MMC;
              bad_d  = 1'b1;
              res_we = 1'b1;
            end else begin
              try_inc = 1'b1;
            end
          end
        endcase
      end

      S_FIN: begin
        st_d = S_IDLE;
      end

      default: st_d = S_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= S_IDLE;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_RST;
      v2_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      v2_q   <= v2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      type_q <= CARD_NONE;
      pres_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (res_we) begin
      type_q <= type_d;
      pres_q <= pres_d;
      bad_q  <= bad_d;
    end
  end

  assign card_type    = type_q;
  assign card_present = pres_q;
  assign card_bad     = bad_q;
  assign init_done    = (st_q == S_FIN);

endmodule

// File: rtl/sdinit_chk.sv
module sdinit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_go,
  input logic       spi_cs_n,
  input logic       spi_start,
  input logic [7:0] spi_tx,
  input logic       spi_busy,
  input logic       spi_done,
  input logic [1:0] card_type,
  input logic       card_present,
  input logic       card_bad,
  input logic       init_done
);
  logic waiting_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         waiting_q <= 1'b0;
    else if (spi_start) waiting_q <= 1'b1;
    else if (spi_done)  waiting_q <= 1'b0;
  end

  // R1
  desel_idle_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start && spi_cs_n) |-> (spi_tx == 8'hFF));

  // R11
  start_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !spi_busy);

  // R11
  single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !waiting_q);

  // R10
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> !init_done);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(card_type) |-> (init_done || $past(init_go)));

  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_present && card_bad));

  // R5
  no_card_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && (card_type == 2'd0)) |-> (!card_present && !card_bad));

  // R7
  present_typed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && card_present) |-> (card_type != 2'd0));
endmodule

bind sdspi_init_seq sdinit_chk u_chk (.*);

// File: tb/sdspi_init_seq_tb.sv
module sdspi_init_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PRE  = 10;
  localparam int POLL = 8;
  localparam int T0   = 4;
  localparam int T8   = 3;
  localparam int TA   = 6;
  localparam int T1   = 5;

  logic       clk, rst_n, init_go;
  logic       spi_cs_n, spi_start, spi_busy, spi_done;
  logic [7:0] spi_tx, spi_rx;
  logic [1:0] card_type;
  logic       card_present, card_bad, init_done;

  int n_chk = 0;
  int n_fail = 0;

  sdspi_init_seq #(
    .PRE_BYTES(PRE), .POLL_BYTES(POLL), .RST_TRIES(T0),
    .IFC_TRIES(T8), .ACMD_TRIES(TA), .MMC_TRIES(T1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .init_go(init_go),
    .spi_cs_n(spi_cs_n), .spi_start(spi_start), .spi_tx(spi_tx),
    .spi_busy(spi_busy), .spi_done(spi_done), .spi_rx(spi_rx),
    .card_type(card_type), .card_present(card_present),
    .card_bad(card_bad), .init_done(init_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // scenario knobs read by the card model
  int sc_c0f, sc_m8, sc_ab, sc_ai, sc_c1b, sc_gapfix;
  logic mdl_clr;

  // card model state
  int n0, n8, n58, n55, n41, n1, deas, pre_cnt, ff_err, fr_err;
  int fpos, phase, gap_left, tidx, ntail, lat;
  bit seen_cs;
  logic [7:0] fr [6];
  logic [7:0] tail [4];
  logic [7:0] r1v, reply;

  function automatic logic [7:0] exp_check(int idx);
    if (idx == 0) return 8'h95;
    if (idx == 8) return 8'h87;
    return 8'h01;
  endfunction

  function automatic logic [31:0] exp_arg(int idx);
    if (idx == 8)  return 32'h0000_01AA;
    if (idx == 41) return 32'h4010_0000;
    return 32'h0;
  endfunction

  function automatic int pick_gap();
    if (sc_gapfix >= 0) return sc_gapfix;
    return $urandom_range(0, POLL - 1);
  endfunction

  always @(posedge clk) begin
    if (mdl_clr) begin
      n0 = 0; n8 = 0; n58 = 0; n55 = 0; n41 = 0; n1 = 0;
      deas = 0; pre_cnt = 0; ff_err = 0; fr_err = 0;
      fpos = 0; phase = 0; seen_cs = 0;
      spi_busy <= 1'b0; spi_done <= 1'b0; spi_rx <= 8'hFF;
    end else begin
      spi_done <= 1'b0;
      if (spi_busy) begin
        if (lat == 0) begin
          spi_busy <= 1'b0;
          spi_done <= 1'b1;
          spi_rx   <= reply;
        end else lat = lat - 1;
      end
      if (spi_start) begin
        spi_busy <= 1'b1;
        lat = $urandom_range(0, 2);
        reply = 8'hFF;
        if (spi_cs_n) begin
          deas++;
          if (spi_tx != 8'hFF) ff_err++;
          if (!seen_cs) pre_cnt++;
          fpos = 0; phase = 0;
        end else begin
          seen_cs = 1;
          if (phase == 0) begin
            fr[fpos] = spi_tx;
            fpos++;
            if (fpos == 6) begin
              int idx;
              idx = int'(fr[0][5:0]);
              if (fr[0][7:6] != 2'b01) fr_err++;
              if ({fr[1], fr[2], fr[3], fr[4]} != exp_arg(idx)) fr_err++;
              if (fr[5] != exp_check(idx)) fr_err++;
              gap_left = pick_gap();
              ntail = 0;
              tidx = 0;
              phase = 1;
              case (idx)
                0: begin n0++; r1v = (n0 <= sc_c0f) ? 8'h00 : 8'h01; end
                8: begin
                  n8++;
                  case (sc_m8)
                    0: begin r1v = 8'h01; ntail = 4;
                       tail[0] = 8'h00; tail[1] = 8'h00; tail[2] = 8'h01; tail[3] = 8'hAA; end
                    1: r1v = 8'h05;
                    2: begin r1v = 8'h01; ntail = 4;
                       tail[0] = 8'h00; tail[1] = 8'h00; tail[2] = 8'h01; tail[3] = 8'h55; end
                    default: begin r1v = 8'hFF; gap_left = 40; end
                  endcase
                end
                58: begin n58++; r1v = 8'h01; ntail = 4;
                    tail[0] = 8'hC0; tail[1] = 8'hFF; tail[2] = 8'h80; tail[3] = 8'h00; end
                55: begin n55++; r1v = 8'h01; end
                41: begin
                  n41++;
                  if (sc_ai != 0)        r1v = 8'h05;
                  else if (n41 <= sc_ab) r1v = 8'h01;
                  else                   r1v = 8'h00;
                end
                1: begin n1++; r1v = (n1 <= sc_c1b) ? 8'h01 : 8'h00; end
                default: begin fr_err++; r1v = 8'h04; end
              endcase
            end
          end else if (phase == 1) begin
            if (gap_left > 0) gap_left--;
            else begin reply = r1v; phase = 2; end
          end else begin
            if (tidx < ntail) begin reply = tail[tidx]; tidx++; end
          end
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_sc(input int c0f, input int m8, input int ab, input int ai,
                        input int c1b, input int gapfix, input bit rego);
    int e0, e8, e58, e41, e1, etype, epres, ebad, k;
    logic [1:0] t_hold;
    sc_c0f = c0f; sc_m8 = m8; sc_ab = ab; sc_ai = ai; sc_c1b = c1b; sc_gapfix = gapfix;
    // expected outcome from the requirements
    e8 = 0; e58 = 0; e41 = 0; e1 = 0; etype = 0; epres = 0; ebad = 0;
    if (c0f >= T0) e0 = T0;                     // R5
    else begin
      e0 = c0f + 1;
      e8 = (m8 == 3) ? T8 : 1;                  // R6
      e58 = (m8 == 0) ? 1 : 0;
      if (ai != 0)      e41 = 1;                // R8
      else if (ab < TA) e41 = ab + 1;           // R7
      else              e41 = TA;
      if (ai == 0 && ab < TA) begin
        etype = (m8 == 0) ? 3 : 2; epres = 1;
      end else begin                            // R9
        etype = 1;
        if (c1b < T1) begin e1 = c1b + 1; epres = 1; end
        else begin e1 = T1; ebad = 1; end
      end
    end
    @(negedge clk) mdl_clr = 1'b1;
    @(negedge clk) mdl_clr = 1'b0;
    init_go = 1'b1;
    @(negedge clk) init_go = 1'b0;
    k = 0;
    while (!init_done && k < 60000) begin
      @(negedge clk);
      k++;
      if (rego && k == 60) init_go = 1'b1;       // R10: ignored mid-run
      else init_go = 1'b0;
    end
    init_go = 1'b0;
    chk("R10 done seen", int'(init_done), 1);
    chk("R5/R7/R9 card_type", int'(card_type), etype);
    chk("R7/R9 card_present", int'(card_present), epres);
    chk("R9 card_bad", int'(card_bad), ebad);
    chk("R5 cmd0 count", n0, e0);
    chk("R6 cmd8 count", n8, e8);
    chk("R6 cmd58 count", n58, e58);
    chk("R7 cmd41 count", n41, e41);
    chk("R7 cmd55 count", n55, e41);
    chk("R9 cmd1 count", n1, e1);
    chk("R1 preamble bytes", pre_cnt, PRE);
    chk("R1 deselected bytes are 0xFF", ff_err, 0);
    chk("R2 frame contents", fr_err, 0);
    chk("R4 idle byte per command", deas, PRE + e0 + e8 + e58 + 2 * e41 + e1);
    t_hold = card_type;
    @(negedge clk);
    chk("R10 done one cycle", int'(init_done), 0);
    repeat (15) @(negedge clk);
    chk("R10 result held", int'(card_type), int'(t_hold));
    chk("R11 engine idle at end", int'(spi_start), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0; init_go = 1'b0; mdl_clr = 1'b1;
    sc_c0f = 0; sc_m8 = 0; sc_ab = 0; sc_ai = 0; sc_c1b = 0; sc_gapfix = -1;
    repeat (4) @(negedge clk);
    chk("R10 reset card_type", int'(card_type), 0);
    chk("R10 reset present", int'(card_present), 0);
    chk("R10 reset bad", int'(card_bad), 0);
    chk("R10 reset done", int'(init_done), 0);
    chk("R4 reset cs_n", int'(spi_cs_n), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mdl_clr = 1'b0;
    chk("R11 no request when idle", int'(spi_start), 0);

    run_sc(0, 0, 0, 0, 0, -1, 0);        // SD v2 straight through
    run_sc(2, 0, 3, 0, 0, 7, 0);         // R3: response in last poll slot
    run_sc(T0, 0, 0, 0, 0, -1, 0);       // R5: reset never idles
    run_sc(T0 - 1, 1, 0, 0, 0, -1, 0);   // R6: old card code
    run_sc(0, 2, 1, 0, 0, -1, 0);        // R6: wrong echo
    run_sc(0, 3, 2, 0, 0, -1, 0);        // R3/R6: interface command times out
    run_sc(0, 0, TA - 1, 0, 0, -1, 0);   // R7: success on last pair
    run_sc(0, 1, TA, 0, 2, -1, 0);       // R8: pairs exhausted
    run_sc(0, 1, 0, 1, T1 - 1, -1, 0);   // R8/R9: illegal bit, MMC on last try
    run_sc(1, 0, 0, 1, T1, -1, 1);       // R9 bad card, R10 restart ignored
    for (int i = 0; i < 16; i++) begin
      int c0f, m8, ab, ai, c1b;
      c0f = ($urandom_range(0, 3) == 0) ? T0 : $urandom_range(0, T0 - 1);
      m8  = $urandom_range(0, 3);
      ab  = $urandom_range(0, TA);
      ai  = ($urandom_range(0, 3) == 0) ? 1 : 0;
      c1b = $urandom_range(0, T1);
      run_sc(c0f, m8, ab, ai, c1b, -1, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule